// File: doc/BRIEF.md
# Memory-Field and Interrupt Controller

This block keeps the memory-extension state of a 12-bit processor whose 32K-word memory is split into eight fields of 4K words each. It holds a 3-bit instruction field, a 3-bit data field, a 3-bit staging buffer for the next instruction field, and a 6-bit save register. Each field register selects one field at a time. The block turns the decoded strobes from the CPU sequencer into updates of these registers. It also prefixes the field number onto 12-bit addresses to form 15-bit memory addresses.

The block also decides when a device interrupt may be taken. Interrupts must first be enabled. The enable takes effect only after the instruction that follows the enabling instruction. Interrupts are held off while a field change is still waiting in the staging buffer. When an interrupt is taken, both fields are saved and cleared. The block then asks the sequencer to run a forced subroutine call to address 0. The return address lands in word 0000 of field 0 and execution continues at 0001. That forced call must not move the staging buffer into the instruction field.

Top module: `field_int_ctrl`

## Requirements
- R1: After reset the instruction field, data field, staging buffer and save register read 0, interrupts are disabled and no forced call is requested.
- R2: A set-instruction-field strobe loads the staging buffer from `fld_i` one cycle later and leaves the instruction field unchanged. The instruction field takes the staging buffer's value on the next `jmp_i` or `jms_i`.
- R3: A set-data-field strobe loads the data field from `fld_i` one cycle later.
- R4: After a set-instruction-field or restore-field strobe, no interrupt is taken until a `jmp_i` or `jms_i` copies the staging buffer into the instruction field.
- R5: An enable strobe does not enable interrupts by itself. The enable appears after the next end-of-instruction strobe, so with a request already present the interrupt is taken at the end of the instruction that follows the enabling one.
- R6: A disable strobe clears the interrupt enable one cycle later and also cancels an enable that is still waiting for its end-of-instruction.
- R7: An interrupt is taken when end-of-instruction, enable and request are all high with no field change pending. One cycle later the save register holds {instruction field, data field} with the instruction field in bits 5:3, the instruction field, data field and staging buffer are 0, interrupts are disabled, and `force_call_o` is 1.
- R8: While `force_call_o` is 1, a `jms_i` strobe clears `force_call_o` and does not copy the staging buffer into the instruction field.
- R9: A restore-field strobe loads the staging buffer from save bits 5:3 and the data field from save bits 2:0, and leaves the instruction field unchanged.
- R10: `fetch_addr_o` is {instruction field, `pc_i`}. `data_addr_o` is {data field, `ea_i`} when `indirect_i` is 1 and {instruction field, `ea_i`} otherwise.
- R11: No interrupt is taken without an end-of-instruction strobe, or while `irq_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cif_i | input | 1 | Set-instruction-field strobe (writes staging buffer) |
| cdf_i | input | 1 | Set-data-field strobe |
| rmf_i | input | 1 | Restore-field strobe |
| jmp_i | input | 1 | Jump executed |
| jms_i | input | 1 | Subroutine call executed |
| ion_i | input | 1 | Interrupt-enable strobe |
| iof_i | input | 1 | Interrupt-disable strobe |
| eoi_i | input | 1 | End-of-instruction strobe |
| fld_i | input | 3 | Field number carried by the field strobes |
| irq_i | input | 1 | Wired-OR device interrupt request |
| pc_i | input | 12 | 12-bit fetch address |
| ea_i | input | 12 | 12-bit operand address |
| indirect_i | input | 1 | Operand access is indirect (use data field) |
| fetch_addr_o | output | 15 | Extended fetch address |
| data_addr_o | output | 15 | Extended operand address |
| if_o | output | 3 | Instruction field |
| df_o | output | 3 | Data field |
| ib_o | output | 3 | Staging buffer |
| sf_o | output | 6 | Save register |
| int_en_o | output | 1 | Interrupt enable |
| force_call_o | output | 1 | Request for forced call to address 0 |

## Verification
The bench drives the interrupt entry path with several strobe orderings, each aimed at one rule.

- An enable followed directly by a request already present shows the one-instruction delay, as distinct from an immediate entry.
- A staged field change followed by end-of-instruction with the request high separates the hold-off from plain gating by the enable.
- A disable given before the enable's delay has run out catches a design that cancels only an enable that has already taken effect.
- A field strobe placed between entry and the forced call exposes a forced call that wrongly copies the staging buffer.
- Non-zero fields before entry and restore-field afterwards show whether the save layout and the restore path agree on bit order.

// File: rtl/fic_pkg.sv
package fic_pkg;
    localparam int FLD_W  = 3;
    localparam int ADDR_W = 12;

    typedef logic [FLD_W-1:0] fld_t;

    typedef struct packed {
        fld_t                 ifld;
        fld_t                 dfld;
        fld_t                 ibuf;
        logic [2*FLD_W-1:0]   save;
        logic                 pend;
    } fregs_t;

    typedef struct packed {
        logic en;
        logic en_wait;
        logic force_call;
    } gate_t;
endpackage

// File: rtl/fic_field_regs.sv
module fic_field_regs
    import fic_pkg::*;
#(
    parameter int FW = FLD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cif_i,
    input  logic            cdf_i,
    input  logic            rmf_i,
    input  logic            jmp_i,
    input  logic            jms_i,
    input  logic [FW-1:0]   fld_i,
    input  logic            take_i,
    input  logic            force_i,
    output logic [FW-1:0]   if_o,
    output logic [FW-1:0]   df_o,
    output logic [FW-1:0]   ib_o,
    output logic [2*FW-1:0] sf_o,
    output logic            pend_o
);
    localparam int SW = 2 * FW;

    logic [FW-1:0] if_d, if_q, df_d, df_q, ib_d, ib_q;
    logic [SW-1:0] sf_d, sf_q;
    logic          pend_d, pend_q;

    always_comb begin
        if_d   = if_q;
        df_d   = df_q;
        ib_d   = ib_q;
        sf_d   = sf_q;
        pend_d = pend_q;
        if (take_i) begin
            sf_d   = {if_q, df_q};
            if_d   = '0;
            df_d   = '0;
            ib_d   = '0;
            pend_d = 1'b0;
        end else begin
            if (rmf_i) begin
                ib_d   = sf_q[SW-1:FW];
                df_d   = sf_q[FW-1:0];
                pend_d = 1'b1;
            end
            if (cif_i) begin
                ib_d   = fld_i;
                pend_d = 1'b1;
            end
            if (cdf_i) begin
                df_d = fld_i;
            end
            if ((jmp_i || jms_i) && !force_i) begin
                if_d   = ib_q;
                pend_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q   <= '0;
            df_q   <= '0;
            ib_q   <= '0;
            sf_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            if_q   <= if_d;
            df_q   <= df_d;
            ib_q   <= ib_d;
            sf_q   <= sf_d;
            pend_q <= pend_d;
        end
    end

    assign if_o   = if_q;
    assign df_o   = df_q;
    assign ib_o   = ib_q;
    assign sf_o   = sf_q;
    assign pend_o = pend_q;

    AST_CIF_IF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cif_i && !jmp_i && !jms_i && !take_i) |=> $stable(if_q)); // R2
    AST_CDF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cdf_i && !take_i) |=> (df_q == $past(fld_i))); // R3
    AST_TAKE_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (sf_q == {$past(if_q), $past(df_q)}) && (if_q == '0) && (df_q == '0) && (ib_q == '0)); // R7
    AST_FORCED_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (jms_i && force_i && !take_i) |=> $stable(if_q)); // R8
    AST_RMF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rmf_i && !cif_i && !cdf_i && !take_i) |=> (ib_q == $past(sf_q[SW-1:FW])) && (df_q == $past(sf_q[FW-1:0]))); // R9
endmodule

// File: rtl/fic_irq_gate.sv
module fic_irq_gate
    import fic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ion_i,
    input  logic iof_i,
    input  logic eoi_i,
    input  logic jms_i,
    input  logic irq_i,
    input  logic pend_i,
    output logic take_o,
    output logic en_o,
    output logic force_o
);
    gate_t g_d, g_q;
    logic  take_w;

    always_comb begin
        take_w = eoi_i && g_q.en && irq_i && !pend_i && !g_q.force_call;
        g_d    = g_q;

        if (iof_i)      g_d.en_wait = 1'b0;
        else if (ion_i) g_d.en_wait = 1'b1;
        else if (eoi_i) g_d.en_wait = 1'b0;

        if (take_w)                      g_d.en = 1'b0;
        else if (iof_i)                  g_d.en = 1'b0;
        else if (eoi_i && g_q.en_wait)   g_d.en = 1'b1;

        if (take_w)     g_d.force_call = 1'b1;
        else if (jms_i) g_d.force_call = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign take_o  = take_w;
    assign en_o    = g_q.en;
    assign force_o = g_q.force_call;

    AST_ION_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ion_i && !eoi_i && !g_q.en) |=> !g_q.en); // R5
    AST_IOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        iof_i |=> !g_q.en); // R6
    AST_TAKE_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        take_w |=> (g_q.force_call && !g_q.en)); // R7
    AST_NO_EOI_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoi_i || !irq_i) |=> !$rose(g_q.force_call)); // R11
endmodule

// File: rtl/fic_addr_ext.sv
module fic_addr_ext
    import fic_pkg::*;
#(
    parameter int FW = FLD_W,
    parameter int AW = ADDR_W
) (
    input  logic [FW-1:0]    if_i,
    input  logic [FW-1:0]    df_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [AW-1:0]    ea_i,
    input  logic             indirect_i,
    output logic [FW+AW-1:0] fetch_o,
    output logic [FW+AW-1:0] data_o
);
    logic [FW-1:0] opnd_fld;

    always_comb begin
        opnd_fld = indirect_i ? df_i : if_i;
        fetch_o  = {if_i, pc_i};
        data_o   = {opnd_fld, ea_i};
    end
endmodule

// File: rtl/field_int_ctrl.sv
module field_int_ctrl
    import fic_pkg::*;
#(
    parameter int FW = FLD_W,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cif_i,
    input  logic             cdf_i,
    input  logic             rmf_i,
    input  logic             jmp_i,
    input  logic             jms_i,
    input  logic             ion_i,
    input  logic             iof_i,
    input  logic             eoi_i,
    input  logic [FW-1:0]    fld_i,
    input  logic             irq_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [AW-1:0]    ea_i,
    input  logic             indirect_i,
    output logic [FW+AW-1:0] fetch_addr_o,
    output logic [FW+AW-1:0] data_addr_o,
    output logic [FW-1:0]    if_o,
    output logic [FW-1:0]    df_o,
    output logic [FW-1:0]    ib_o,
    output logic [2*FW-1:0]  sf_o,
    output logic             int_en_o,
    output logic             force_call_o
);
    logic          take_w, pend_w, force_w;
    logic [FW-1:0] if_w, df_w;

    fic_field_regs #(.FW(FW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cif_i   (cif_i),
        .cdf_i   (cdf_i),
        .rmf_i   (rmf_i),
        .jmp_i   (jmp_i),
        .jms_i   (jms_i),
        .fld_i   (fld_i),
        .take_i  (take_w),
        .force_i (force_w),
        .if_o    (if_w),
        .df_o    (df_w),
        .ib_o    (ib_o),
        .sf_o    (sf_o),
        .pend_o  (pend_w)
    );

    fic_irq_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .ion_i   (ion_i),
        .iof_i   (iof_i),
        .eoi_i   (eoi_i),
        .jms_i   (jms_i),
        .irq_i   (irq_i),
        .pend_i  (pend_w),
        .take_o  (take_w),
        .en_o    (int_en_o),
        .force_o (force_w)
    );

    fic_addr_ext #(.FW(FW), .AW(AW)) u_addr (
        .if_i       (if_w),
        .df_i       (df_w),
        .pc_i       (pc_i),
        .ea_i       (ea_i),
        .indirect_i (indirect_i),
        .fetch_o    (fetch_addr_o),
        .data_o     (data_addr_o)
    );

    assign if_o         = if_w;
    assign df_o         = df_w;
    assign force_call_o = force_w;

    AST_PEND_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w |-> !take_w); // R4
endmodule

// File: tb/field_int_ctrl_tb_top.sv
module field_int_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cif = 0, cdf = 0, rmf = 0, jmp = 0, jms = 0, ion = 0, iof = 0, eoi = 0;
    logic [2:0]  fld = '0;
    logic        irq = 0;
    logic [11:0] pc = '0, ea = '0;
    logic        ind = 0;
    logic [14:0] fetch_addr, data_addr;
    logic [2:0]  if_f, df_f, ib_f;
    logic [5:0]  sf_f;
    logic        int_en, force_call;
    int          n_checks = 0;
    int          n_errors = 0;

    always #10 clk = ~clk;

    field_int_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cif_i(cif), .cdf_i(cdf), .rmf_i(rmf),
        .jmp_i(jmp), .jms_i(jms), .ion_i(ion), .iof_i(iof), .eoi_i(eoi),
        .fld_i(fld), .irq_i(irq), .pc_i(pc), .ea_i(ea), .indirect_i(ind),
        .fetch_addr_o(fetch_addr), .data_addr_o(data_addr),
        .if_o(if_f), .df_o(df_f), .ib_o(ib_f), .sf_o(sf_f),
        .int_en_o(int_en), .force_call_o(force_call)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic c_cif, c_cdf, c_rmf, c_jmp, c_jms,
                        c_ion, c_iof, c_eoi, input logic [2:0] f);
        cif = c_cif; cdf = c_cdf; rmf = c_rmf; jmp = c_jmp; jms = c_jms;
        ion = c_ion; iof = c_iof; eoi = c_eoi; fld = f;
        @(negedge clk);
        cif = 0; cdf = 0; rmf = 0; jmp = 0; jms = 0;
        ion = 0; iof = 0; eoi = 0; fld = '0;
    endtask

    task automatic do_reset();
        irq = 0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic enable_ints();
        step(0,0,0,0,0,1,0,0,3'd0);
        step(0,0,0,0,0,0,0,1,3'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "if", if_f, 0);
        chk("R1", "df", df_f, 0);
        chk("R1", "ib", ib_f, 0);
        chk("R1", "sf", sf_f, 0);
        chk("R1", "int_en", int_en, 0);
        chk("R1", "force", force_call, 0);
    endtask

    task automatic t_fields();
        do_reset();
        step(1,0,0,0,0,0,0,0,3'd5);
        chk("R2", "ib after cif", ib_f, 5);
        chk("R2", "if held after cif", if_f, 0);
        step(0,1,0,0,0,0,0,0,3'd3);
        chk("R3", "df after cdf", df_f, 3);
        chk("R2", "if before jump", if_f, 0);
        step(0,0,0,1,0,0,0,0,3'd0);
        chk("R2", "if after jmp", if_f, 5);
        pc = 12'h123; ea = 12'h456; ind = 1'b1;
        #1;
        chk("R10", "fetch addr", fetch_addr, 15'h5123);
        chk("R10", "indirect data addr", data_addr, 15'h3456);
        ind = 1'b0;
        #1;
        chk("R10", "direct data addr", data_addr, 15'h5456);
    endtask

    task automatic t_entry();
        do_reset();
        step(1,0,0,0,0,0,0,0,3'd5);
        step(0,1,0,0,0,0,0,0,3'd3);
        step(0,0,0,1,0,0,0,0,3'd0);
        irq = 1'b1;
        step(0,0,0,0,0,1,0,0,3'd0);
        chk("R5", "enable not immediate", int_en, 0);
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R5", "enable after ION ends", int_en, 1);
        chk("R5", "no entry at end of ION", force_call, 0);
        step(0,0,0,0,0,0,0,0,3'd0);
        chk("R11", "no entry without eoi", force_call, 0);
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R7", "force after entry", force_call, 1);
        chk("R7", "enable cleared", int_en, 0);
        chk("R7", "save = {if,df}", sf_f, 6'o53);
        chk("R7", "if cleared", if_f, 0);
        chk("R7", "df cleared", df_f, 0);
        chk("R7", "ib cleared", ib_f, 0);
        irq = 1'b0;
        step(1,0,0,0,0,0,0,0,3'd2);
        step(0,0,0,0,1,0,0,0,3'd0);
        chk("R8", "force cleared by jms", force_call, 0);
        chk("R8", "if not copied by forced jms", if_f, 0);
        chk("R8", "ib kept", ib_f, 2);
    endtask

    task automatic t_restore();
        t_entry();
        step(0,0,0,1,0,0,0,0,3'd0);
        step(0,0,0,0,0,0,0,0,3'd0);
        step(0,0,1,0,0,0,0,0,3'd0);
        chk("R9", "ib from save", ib_f, 5);
        chk("R9", "df from save", df_f, 3);
        chk("R9", "if unchanged", if_f, 2);
        enable_ints();
        chk("R4", "enabled", int_en, 1);
        irq = 1'b1;
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R4", "held off while pending", force_call, 0);
        step(0,0,0,1,0,0,0,0,3'd0);
        chk("R4", "if loaded by jmp", if_f, 5);
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R4", "entry after jmp", force_call, 1);
        irq = 1'b0;
    endtask

    task automatic t_disable();
        do_reset();
        enable_ints();
        step(0,0,0,0,0,0,1,0,3'd0);
        chk("R6", "iof clears enable", int_en, 0);
        step(0,0,0,0,0,1,0,0,3'd0);
        step(0,0,0,0,0,0,1,0,3'd0);
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R6", "iof cancels waiting enable", int_en, 0);
        irq = 1'b1;
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R6", "no entry while disabled", force_call, 0);
        irq = 1'b0;
        enable_ints();
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R11", "no entry without request", force_call, 0);
        irq = 1'b1;
        step(1,0,0,0,0,0,0,0,3'd1);
        step(0,0,0,0,0,0,0,1,3'd0);
        chk("R4", "cif holds off entry", force_call, 0);
        irq = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fields();
        t_entry();
        t_restore();
        t_disable();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule